// File: doc/BRIEF.md
# Triggered Pulse Generator Timer

This block produces one timed pulse each time it is started. A start loads an 8-bit pulse-width value and drives the pulse output high. The timer then counts that value down on ticks from a clock prescaler, and the pulse falls when the count runs out. There are three ways to start or stop a pulse. Software starts or stops it through a bit of the control register. A rising edge on the first comparator result can cut a running pulse short. A rising edge on the second comparator result can start a fresh pulse.

The control register is written over a simple bus write port and can be read back in full. Each comparator trigger has two gates: its own comparator-enable bit and a trigger-enable bit. Both comparator inputs are asynchronous. They pass through a two-flop synchronizer, and only their rising edges act. A busy output reports whether the timer is running.

Top module: `pulse_gen_timer`

## Requirements
- R1: After reset, ctrl_q reads 0x00 and both pulse_out and busy are low.
- R2: A write with wr_en high stores wr_data into ctrl_q on that clock edge. The control layout is: bit 7 software trigger, bit 6 restart-enable, bit 5 stop-enable, bits 4..2 prescaler select, bit 1 comparator 1 enable, bit 0 comparator 0 enable.
- R3: A pulse that is not interrupted lasts width × 2^sel clock cycles, where sel is the value in ctrl bits 4..2 (codes 0 to 7 give dividers of 1 to 128).
- R4: A write with bit 7 set starts a pulse. pulse_out rises on the same edge that takes the write. A second such write during a pulse reloads the width, so the pulse lasts a full width × 2^sel from that write.
- R5: A write with bit 7 clear ends a running pulse on the edge that takes the write.
- R6: When ctrl bits 5 and 0 are both 1, a rising edge on cmp0_in ends the pulse, and pulse_out is low after the third clock edge following the change. If either bit is 0, cmp0_in is ignored.
- R7: When ctrl bits 6 and 1 are both 1, a rising edge on cmp1_in starts a pulse, and pulse_out is high after the third clock edge following the change. If either bit is 0, cmp1_in is ignored.
- R8: The comparator triggers act on edges only. Holding cmp0_in high does not stop a pulse that was started after the edge.
- R9: When a stop and a start arrive in the same cycle, the start wins.
- R10: A start with a width of 0 produces no pulse, and busy stays low.
- R11: busy is high exactly while pulse_out is high.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| wr_en | input | 1 | Write strobe for the control register |
| wr_data | input | 8 | Control value to write |
| width | input | 8 | Pulse width in prescaled ticks |
| cmp0_in | input | 1 | Comparator 0 result, asynchronous (stop source) |
| cmp1_in | input | 1 | Comparator 1 result, asynchronous (restart source) |
| ctrl_q | output | 8 | Control register readback |
| pulse_out | output | 1 | Pulse output |
| busy | output | 1 | Timer running status |

## Verification
A software write takes effect on the edge that samples it, so the bench samples pulse_out at the falling edge just after that edge. A comparator change goes through two synchronizer flops and one edge-detect flop. The bench therefore requires pulse_out unchanged after the first and second edges and changed after the third. To get the pulse length, the bench counts falling edges while the output is high, starting at the first one after the start. For each width and prescaler code, it compares that count with width × 2^sel.

// File: rtl/pulse_gen_timer.sv
module pulse_gen_timer #(
  parameter int W = 8
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         wr_en,
  input  logic [7:0]   wr_data,
  input  logic [W-1:0] width,
  input  logic         cmp0_in,
  input  logic         cmp1_in,
  output logic [7:0]   ctrl_q,
  output logic         pulse_out,
  output logic         busy
);
  localparam int SEL_W = 3;
  localparam int PS_W  = (1 << SEL_W) - 1;

  logic [1:0]      c0_sync, c1_sync;
  logic            c0_prev, c1_prev;
  logic [W-1:0]    cnt;
  logic [PS_W-1:0] psc;
  logic            active;

  wire c0_gated = c0_sync[1] & ctrl_q[0];
  wire c1_gated = c1_sync[1] & ctrl_q[1];
  wire c0_rise  = c0_gated & ~c0_prev;
  wire c1_rise  = c1_gated & ~c1_prev;

  wire restart_ev = (wr_en & wr_data[7]) | (ctrl_q[6] & c1_rise);
  wire stop_ev    = (wr_en & ~wr_data[7]) | (ctrl_q[5] & c0_rise);

  wire [PS_W-1:0] lim = ~({PS_W{1'b1}} << ctrl_q[4:2]);
  wire tick = psc >= lim;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ctrl_q  <= '0;
      c0_sync <= '0;
      c1_sync <= '0;
      c0_prev <= 1'b0;
      c1_prev <= 1'b0;
    end else begin
      if (wr_en) ctrl_q <= wr_data;
      c0_sync <= {c0_sync[0], cmp0_in};
      c1_sync <= {c1_sync[0], cmp1_in};
      c0_prev <= c0_gated;
      c1_prev <= c1_gated;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt    <= '0;
      psc    <= '0;
      active <= 1'b0;
    end else if (restart_ev) begin
      cnt    <= width;
      psc    <= '0;
      active <= (width != '0);
    end else if (stop_ev) begin
      cnt    <= '0;
      psc    <= '0;
      active <= 1'b0;
    end else if (active) begin
      if (tick) begin
        psc <= '0;
        cnt <= cnt - 1'b1;
        if (cnt == W'(1)) active <= 1'b0;
      end else begin
        psc <= psc + 1'b1;
      end
    end
  end

  assign pulse_out = active;
  assign busy      = active;

  // R5
  stop_ends_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (stop_ev && !restart_ev) |=> !pulse_out);

  // R4
  restart_loads_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (restart_ev && width != '0) |=> (pulse_out && cnt == $past(width)));

  // R3
  count_down_only_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (active && !restart_ev) |=> (cnt <= $past(cnt)));

  // R6
  cmp0_disabled_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !ctrl_q[0] |=> !c0_prev);

  // R10
  pulse_has_count_chk: assert property (@(posedge clk) disable iff (!rst_n)
    pulse_out |-> (cnt != '0));
endmodule

// File: tb/pulse_gen_timer_tb_top.sv
`timescale 1ns/1ps
module pulse_gen_timer_tb_top;
  logic clk = 0, rst_n = 0, wr_en = 0, cmp0_in = 0, cmp1_in = 0;
  logic [7:0] wr_data = 0, width = 0, ctrl_q;
  logic pulse_out, busy;
  int checks = 0, errors = 0;

  always #2.5 clk = ~clk;

  pulse_gen_timer dut_i (.clk, .rst_n, .wr_en, .wr_data, .width, .cmp0_in,
    .cmp1_in, .ctrl_q, .pulse_out, .busy);

  // {sel, width, expected cycles}
  localparam logic [26:0] VEC [8] = '{
    {3'd0, 8'd5, 16'd5},   {3'd1, 8'd3, 16'd6},  {3'd2, 8'd4, 16'd16},
    {3'd3, 8'd1, 16'd8},   {3'd7, 8'd2, 16'd256}, {3'd4, 8'd10, 16'd160},
    {3'd5, 8'd1, 16'd32},  {3'd6, 8'd3, 16'd192}};

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic wr(input logic [7:0] d);
    @(negedge clk); wr_en = 1; wr_data = d;
    @(negedge clk); wr_en = 0;
  endtask

  task automatic measure(output int n);
    bit bad = 0;
    n = 0;
    while (pulse_out && n < 3000) begin
      if (busy !== pulse_out) bad = 1;
      n++;
      @(negedge clk);
    end
    chk(!bad, "R11 busy follows pulse", int'(bad), 0);
  endtask

  task automatic idle(input int k);
    for (int i = 0; i < k; i++) @(negedge clk);
  endtask

  initial begin
    #1_000_000;
    errors++; checks++;
    $display("FAIL watchdog actual=1 expected=0");
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    int n;
    idle(2);
    chk(ctrl_q == 8'h00, "R1 ctrl reset", ctrl_q, 0);
    chk(!pulse_out && !busy, "R1 outputs reset", pulse_out, 0);
    rst_n = 1;
    idle(2);

    wr(8'h5D);
    chk(ctrl_q == 8'h5D, "R2 ctrl write", ctrl_q, 8'h5D);

    for (int i = 0; i < 8; i++) begin
      width = VEC[i][23:16];
      wr({1'b1, 2'b00, VEC[i][26:24], 2'b00});
      measure(n);
      chk(n == int'(VEC[i][15:0]), "R3 pulse length", n, int'(VEC[i][15:0]));
    end

    width = 10;
    wr(8'h80); idle(4);
    wr(8'h80);
    measure(n);
    chk(n == 10, "R4 reload on rewrite", n, 10);

    width = 20;
    wr(8'h80); idle(3);
    wr(8'h00);
    chk(!pulse_out, "R5 software stop", pulse_out, 0);

    width = 50;
    wr(8'hA1);
    cmp0_in = 1;
    @(negedge clk); chk(pulse_out, "R6 stop not early 1", pulse_out, 1);
    @(negedge clk); chk(pulse_out, "R6 stop not early 2", pulse_out, 1);
    @(negedge clk); chk(!pulse_out, "R6 cmp0 stop", pulse_out, 0);

    wr(8'hA1); idle(6);
    chk(pulse_out, "R8 held level ignored", pulse_out, 1);
    cmp0_in = 0; idle(4);

    wr(8'h81);
    cmp0_in = 1; idle(6);
    chk(pulse_out, "R6 stop-enable off ignored", pulse_out, 1);
    cmp0_in = 0; idle(4);
    wr(8'hA0); idle(3);
    cmp0_in = 1; idle(6);
    chk(pulse_out, "R6 comparator disabled ignored", pulse_out, 1);
    cmp0_in = 0;
    wr(8'h00); idle(4);

    width = 6;
    wr(8'h42);
    cmp1_in = 1;
    @(negedge clk);
    @(negedge clk); chk(!pulse_out, "R7 start not early", pulse_out, 0);
    @(negedge clk); chk(pulse_out, "R7 cmp1 start", pulse_out, 1);
    measure(n);
    chk(n == 6, "R7 cmp1 pulse length", n, 6);
    cmp1_in = 0; idle(4);

    wr(8'h02);
    cmp1_in = 1; idle(6);
    chk(!pulse_out, "R7 restart-enable off ignored", pulse_out, 0);
    cmp1_in = 0; idle(4);

    width = 7;
    wr(8'h42);
    cmp1_in = 1;
    @(negedge clk); @(negedge clk);
    wr_en = 1; wr_data = 8'h42;
    @(negedge clk); wr_en = 0;
    chk(pulse_out, "R9 start wins", pulse_out, 1);
    measure(n);
    chk(n == 7, "R9 pulse length", n, 7);
    cmp1_in = 0; idle(4);

    width = 0;
    wr(8'h80);
    chk(!pulse_out && !busy, "R10 zero width", pulse_out, 0);

    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule